// File: doc/BRIEF.md
# Frequency-Change Watchdog Recovery Controller

This block guards software-driven clock frequency changes. Software writes a new frequency code through a small register port. If a nonzero timeout code has been programmed beforehand, that write also starts a watchdog. Software is expected to confirm that the system survived the new frequency by writing the timeout code back to zero. If the confirmation does not arrive before the watchdog expires, the block pulls the system reset line low for a fixed number of millisecond ticks.

The first expiry only resets the system. Every later expiry also returns the clock to the hardware-strapped selection and pulses a relatch request to the strap logic. The cycle repeats until software clears the timeout code. Clearing the code stops the watchdog and clears the alarm flag, and the frequency that is selected at that moment is kept.

Timing is counted in ticks of a 1 ms strobe. The watchdog period is the timeout code multiplied by a parameter. The reset output is an open-drain enable: 1 means the pad is pulled low.

Top module: `freq_wdog_recovery`

## Requirements
- R1: After reset, `rst_od_en` and `relatch_req` are 0, `status` is 0, and `freq_sel` equals `strap_sel`.
- R2: A write to the frequency register (`wr_addr`=0) while the timeout code is 0 drives `freq_sel` to `wr_data[FW-1:0]` on the next cycle, and no reset pulse follows.
- R3: A write to the frequency register while the timeout code is nonzero updates `freq_sel` and starts the watchdog from zero. The expiry happens on the (code × `TICKS_PER_CODE`)-th tick after the write cycle.
- R4: On the first expiry after the watchdog is armed, `rst_od_en` rises in the cycle after the expiring tick and the alarm flag is set. There is no relatch and `freq_sel` is unchanged.
- R5: On each later expiry, the block also raises `relatch_req` for exactly one cycle and `freq_sel` returns to `strap_sel`.
- R6: The watchdog is held during a reset pulse and counts again from zero once the pulse ends. The next expiry comes on the (code × `TICKS_PER_CODE`)-th tick after the release.
- R7: Writing 0 to the timeout code (`wr_addr`=1, `wr_data[3:0]`=0) stops the watchdog and clears the alarm flag. It keeps `freq_sel`, and it lets a pulse already in progress run to its end.
- R8: `status` reads {3'b000, alarm, timeout code}, with the alarm in bit 4 and the code in bits 3:0. Bit 4 of a control write is ignored, so the alarm cannot be set or cleared by writing that bit.
- R9: In a cycle with any register write, a tick does not advance the watchdog.
- R10: `rst_od_en` is 1 only during a pulse. A pulse lasts exactly `PULSE_TICKS` ticks after the expiry cycle and is not extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe, once per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = frequency register, 1 = control register |
| wr_data | input | 8 | Write data |
| strap_sel | input | FW | Hardware-strapped frequency selection |
| freq_sel | output | FW | Frequency selection in effect |
| relatch_req | output | 1 | One-cycle request to relatch the strap selection |
| rst_od_en | output | 1 | Open-drain enable for the system reset (1 = pull low) |
| status | output | 8 | {3'b000, alarm, timeout code} |

## Verification
The collision that matters is between a register write and the watchdog step that would expire on the same tick. The write must win, and the expiry must move to the next tick. This is provoked directly by a control write issued together with the expiring tick. It also occurs through random traffic in which writes and ticks overlap freely. A second overlap places a timeout-code clear inside a running pulse: the alarm must drop at once while the reset line stays low until the pulse ends. Both cases are judged cycle by cycle against a bench model that applies the stated precedence.

// File: rtl/freq_wdog_recovery.sv
module freq_wdog_recovery #(
  parameter int FW             = 8,
  parameter int TICKS_PER_CODE = 2,
  parameter int PULSE_TICKS    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [FW-1:0] strap_sel,
  output logic [FW-1:0] freq_sel,
  output logic          relatch_req,
  output logic          rst_od_en,
  output logic [7:0]    status
);
  localparam int CW = $clog2(15 * TICKS_PER_CODE + 1);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [3:0]    code;
  logic          alarm, armed, once, use_strap, relatch_q;
  logic [CW-1:0] count;
  logic [PW-1:0] pulse_left;
  logic [FW-1:0] freq_q;

  logic          wr_freq, wr_ctrl, step, expire;
  logic [CW-1:0] limit;

  assign wr_freq = wr_en & ~wr_addr;
  assign wr_ctrl = wr_en & wr_addr;
  assign limit   = CW'(code) * CW'(TICKS_PER_CODE);
  assign step    = tick_ms & armed & (pulse_left == '0) & ~wr_en;
  assign expire  = step & (count >= limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code       <= '0;
      alarm      <= 1'b0;
      armed      <= 1'b0;
      once       <= 1'b0;
      use_strap  <= 1'b1;
      relatch_q  <= 1'b0;
      count      <= '0;
      pulse_left <= '0;
      freq_q     <= '0;
    end else begin
      relatch_q <= 1'b0;
      if (tick_ms && pulse_left != '0)
        pulse_left <= pulse_left - PW'(1);
      if (wr_ctrl) begin
        code <= wr_data[3:0];
        if (wr_data[3:0] == 4'd0) begin
          armed <= 1'b0;
          alarm <= 1'b0;
          once  <= 1'b0;
          count <= '0;
        end
      end else if (wr_freq) begin
        freq_q    <= wr_data[FW-1:0];
        use_strap <= 1'b0;
        if (code != 4'd0) begin
          armed <= 1'b1;
          once  <= 1'b0;
          count <= '0;
        end
      end else if (step) begin
        if (expire) begin
          count      <= '0;
          alarm      <= 1'b1;
          pulse_left <= PW'(PULSE_TICKS);
          once       <= 1'b1;
          if (once) begin
            use_strap <= 1'b1;
            relatch_q <= 1'b1;
          end
        end else begin
          count <= count + CW'(1);
        end
      end
    end
  end

  assign freq_sel    = use_strap ? strap_sel : freq_q;
  assign relatch_req = relatch_q;
  assign rst_od_en   = (pulse_left != '0);
  assign status      = {3'b000, alarm, code};
endmodule

// File: rtl/freq_wdog_recovery_chk.sv
module freq_wdog_recovery_chk #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_addr,
  input logic [7:0]    wr_data,
  input logic [FW-1:0] strap_sel,
  input logic [FW-1:0] freq_sel,
  input logic          relatch_req,
  input logic          rst_od_en,
  input logic [7:0]    status
);
  AST_RELATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) relatch_req |=> !relatch_req); // R5
  AST_RELATCH_TO_STRAP: assert property (@(posedge clk) disable iff (!rst_n) relatch_req |-> freq_sel == strap_sel); // R5
  AST_CLEAR_DROPS_ALARM: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr && wr_data[3:0] == 4'd0) |=> status[4:0] == 5'd0); // R7
  AST_PULSE_SETS_ALARM: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_od_en) |-> status[4]); // R4
  AST_ALARM_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr && wr_data[3:0] != 4'd0) |=> status[4] == $past(status[4])); // R8
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (status[3:0] == 4'd0) |=> !$rose(rst_od_en)); // R2
endmodule

bind freq_wdog_recovery freq_wdog_recovery_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .strap_sel(strap_sel), .freq_sel(freq_sel), .relatch_req(relatch_req),
  .rst_od_en(rst_od_en), .status(status)
);

// File: tb/test_freq_wdog_recovery.sv
module test_freq_wdog_recovery;
  localparam int FW = 8, UNIT = 2, PULSE = 3;

  logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0, wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [FW-1:0] strap_sel = 8'h5A;
  logic [FW-1:0] freq_sel;
  logic relatch_req, rst_od_en;
  logic [7:0] status;
  int checks = 0, failures = 0;
  bit cmp_on = 1'b0;

  freq_wdog_recovery #(.FW(FW), .TICKS_PER_CODE(UNIT), .PULSE_TICKS(PULSE)) i_freq_wdog_recovery (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .strap_sel(strap_sel), .freq_sel(freq_sel),
    .relatch_req(relatch_req), .rst_od_en(rst_od_en), .status(status));

  always #5 clk = ~clk;

  // reference model built from the requirements
  int m_code, m_cnt, m_pulse;
  bit m_alarm, m_armed, m_once, m_strap, m_rl;
  logic [7:0] m_freq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_cnt = 0; m_pulse = 0; m_alarm = 0; m_armed = 0;
      m_once = 0; m_strap = 1; m_rl = 0; m_freq = 0;
    end else begin
      automatic int p0 = m_pulse;
      m_rl = 0;
      if (tick_ms && m_pulse > 0) m_pulse--;
      if (wr_en && wr_addr) begin
        m_code = int'(wr_data[3:0]);
        if (m_code == 0) begin m_armed = 0; m_alarm = 0; m_once = 0; m_cnt = 0; end
      end else if (wr_en) begin
        m_freq = wr_data; m_strap = 0;
        if (m_code != 0) begin m_armed = 1; m_once = 0; m_cnt = 0; end
      end else if (tick_ms && m_armed && p0 == 0) begin
        if (m_cnt + 1 >= m_code * UNIT) begin
          m_cnt = 0; m_alarm = 1; m_pulse = PULSE;
          if (m_once) begin m_strap = 1; m_rl = 1; end
          m_once = 1;
        end else m_cnt++;
      end
    end
  end

  function automatic logic [7:0] exp_status();
    return {3'b000, m_alarm, 4'(m_code)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R10 model rst_od_en", 32'(rst_od_en), 32'(m_pulse > 0));
    chk("R8 model status", 32'(status), 32'(exp_status()));
    chk("R5 model freq_sel", 32'(freq_sel), 32'(m_strap ? strap_sel : m_freq));
    chk("R5 model relatch_req", 32'(relatch_req), 32'(m_rl));
  end

  task automatic cyc(input logic t, input logic w, input logic a, input logic [7:0] d);
    tick_ms = t; wr_en = w; wr_addr = a; wr_data = d;
    @(negedge clk);
    tick_ms = 1'b0; wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 rst_od_en", 32'(rst_od_en), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 freq_sel", 32'(freq_sel), 32'h5A);
    chk("R1 relatch_req", 32'(relatch_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;

    cyc(0, 1, 0, 8'h33);
    chk("R2 freq_sel", 32'(freq_sel), 32'h33);
    for (int i = 0; i < 20; i++) begin ticks(1); chk("R2 no pulse", 32'(rst_od_en), 0); end

    cyc(0, 1, 1, 8'h12);
    chk("R8 alarm bit not writable", 32'(status), 32'h02);

    cyc(0, 1, 0, 8'h44);
    chk("R3 freq_sel", 32'(freq_sel), 32'h44);
    ticks(3);
    chk("R3 not yet expired", 32'(rst_od_en), 0);
    ticks(1);
    chk("R4 pulse", 32'(rst_od_en), 1);
    chk("R4 alarm", 32'(status), 32'h12);
    chk("R4 no relatch", 32'(relatch_req), 0);
    chk("R4 freq kept", 32'(freq_sel), 32'h44);
    ticks(2);
    chk("R10 pulse held", 32'(rst_od_en), 1);
    ticks(1);
    chk("R10 pulse released", 32'(rst_od_en), 0);

    ticks(3);
    chk("R6 restart from zero", 32'(rst_od_en), 0);
    ticks(1);
    chk("R6 second expiry", 32'(rst_od_en), 1);
    chk("R5 relatch", 32'(relatch_req), 1);
    chk("R5 strap freq", 32'(freq_sel), 32'h5A);
    cyc(0, 0, 0, 8'h00);
    chk("R5 relatch one cycle", 32'(relatch_req), 0);

    ticks(3);
    ticks(3);
    cyc(1, 1, 1, 8'h02);
    chk("R9 write blocks step", 32'(rst_od_en), 0);
    chk("R8 alarm kept", 32'(status), 32'h12);
    ticks(1);
    chk("R9 expiry one tick late", 32'(rst_od_en), 1);

    cyc(0, 1, 1, 8'h00);
    chk("R7 alarm cleared", 32'(status), 0);
    chk("R7 pulse continues", 32'(rst_od_en), 1);
    chk("R7 freq kept", 32'(freq_sel), 32'h5A);
    ticks(3);
    chk("R7 pulse ends", 32'(rst_od_en), 0);
    for (int i = 0; i < 20; i++) begin ticks(1); chk("R7 disarmed", 32'(rst_od_en), 0); end

    for (int i = 0; i < 4000; i++) begin
      automatic logic t = ($urandom % 3) == 0;
      automatic logic w = ($urandom % 12) == 0;
      automatic logic a = $urandom % 2;
      automatic logic [7:0] d = a ? 8'(($urandom % 2 ? 8'h10 : 8'h00) | ($urandom % 4)) : 8'($urandom);
      cyc(t, w, a, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule